// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block picks the feedback division ratio for every feedback cycle of a fractional-N synthesizer. Over time the average division comes out as INT + FRAC/MOD. Each feedback-cycle strobe moves a first-order phase accumulator forward by FRAC. When the accumulator wraps past MOD, that one cycle divides by INT + 1. Every other cycle divides by INT.

The ratio for each cycle is also split into the two counts that a dual-modulus prescaler needs: a swallow count and a main count. The prescaler is either 4/5 or 8/9. A flag is raised whenever a ratio falls below the smallest ratio the chosen prescaler can produce.

After a channel change, the accumulator is cleared. It then waits a programmable number of feedback cycles before it starts accumulating again, so that the phase relationship is the same after every retune. A counter-hold input keeps everything in its reset state.

Top module: `fracn_ratio_seq`

## Requirements
- R1: After a synchronous reset, `n_out`, `swallow_out`, `main_out` and `range_err` are all zero, and the internal accumulator is zero.
- R2: On each accepted `fb_tick`, the accumulator adds the effective FRAC step. If the sum is at least MOD, MOD is subtracted and the ratio is INT+1; otherwise the ratio is INT. The outputs show this one clock edge after the tick is sampled.
- R3: Start with the accumulator at zero, MOD non-zero and FRAC no greater than MOD. Then any MOD consecutive accumulating ticks produce exactly FRAC ratios of INT+1, so the average is INT + FRAC/MOD.
- R4: If FRAC is greater than MOD, MOD is used as the step, so every tick yields INT+1. If MOD is zero, there is no fractional part and every tick yields INT.
- R5: With `presc_sel`=0 (4/5 prescaler), `swallow_out` = N mod 4 and `main_out` = N div 4.
- R6: With `presc_sel`=1 (8/9 prescaler), `swallow_out` = N mod 8 and `main_out` = N div 8.
- R7: `range_err` is 1 for a cycle whose N is below 31 in 4/5 mode, or below 91 in 8/9 mode. Otherwise it is 0.
- R8: A `chan_load` pulse clears the accumulator and loads the resync delay. A tick in that same cycle is ignored and the outputs stay unchanged. The next `resync_dly` ticks yield N = INT with no accumulation.
- R9: Once the delay has run out, accumulation restarts from zero. A delay of zero restarts on the very next tick.
- R10: While `cnt_hold` is 1, the accumulator, the delay counter and all outputs are held at their reset values. Ticks and channel loads are ignored; hold has priority over both.
- R11: In a cycle with no accepted tick, all outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_tick | input | 1 | One-cycle strobe, once per feedback cycle |
| chan_load | input | 1 | Channel-change strobe, starts the resync delay |
| cnt_hold | input | 1 | Hold counters and accumulator in reset state |
| int_val | input | 9 | Integer part of the ratio |
| frac_val | input | 12 | Fractional numerator |
| mod_val | input | 12 | Fractional modulus |
| presc_sel | input | 1 | 0: 4/5 prescaler, 1: 8/9 prescaler |
| resync_dly | input | 12 | Restart delay in feedback cycles |
| n_out | output | 10 | Division ratio of the current cycle |
| swallow_out | output | 3 | Prescaler swallow count (N mod P) |
| main_out | output | 8 | Prescaler main count (N div P) |
| range_err | output | 1 | Ratio below the prescaler minimum |

## Verification
All four outputs are registered. They take the result of a tick, a channel load or a hold at the first rising edge that samples that input, and the reset state one edge after reset. The bench therefore drives every input on a falling edge and reads the outputs on the next falling edge, half a period after the only register stage has updated. A golden accumulator in the bench advances only on the ticks the block accepts. It predicts the ratio, split and flag for each tick, including the ticks spent in a resync delay.

// File: rtl/fracn_seq_pkg.sv
package fracn_seq_pkg;
  typedef enum logic {
    PS_4_5 = 1'b0,
    PS_8_9 = 1'b1
  } presc_e;

  // log2 of the lower-modulus value of the 4/5 core; the 8/9 mode adds one
  localparam int P_LOG2_BASE = 2;
  localparam int NUM_MODES   = 2;
endpackage

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [FRAC_W-1:0] mod_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q, acc_nxt, step_sz;
  logic [FRAC_W:0]   sum;
  logic              frac_on;

  always_comb begin
    frac_on = (mod_i != '0);
    if (!frac_on)              step_sz = '0;
    else if (frac_i > mod_i)   step_sz = mod_i;
    else                       step_sz = frac_i;
    sum     = {1'b0, acc_q} + {1'b0, step_sz};
    carry_o = frac_on && (sum >= {1'b0, mod_i});
    acc_nxt = carry_o ? FRAC_W'(sum - {1'b0, mod_i}) : sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || hold || clear) acc_q <= '0;
    else if (step)            acc_q <= acc_nxt;
  end

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (acc_q == '0));

  // R9
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc_q == '0));

  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !hold && !clear && frac_on && (acc_q < mod_i)) |=> (acc_q < $past(mod_i)));
endmodule

// File: rtl/resync_timer.sv
module resync_timer #(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             load,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly_i,
  output logic             busy_o
);
  logic [DLY_W-1:0] wait_q;

  assign busy_o = (wait_q != '0);

  always_ff @(posedge clk) begin
    if (rst || hold)           wait_q <= '0;
    else if (load)             wait_q <= dly_i;
    else if (tick && busy_o)   wait_q <= wait_q - 1'b1;
  end

  // R8
  dly_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !hold) |=> (wait_q == $past(dly_i)));

  // R8
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && !hold && (wait_q != '0)) |=> (wait_q == $past(wait_q) - 1'b1));

  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (wait_q == '0));
endmodule

// File: rtl/presc_split.sv
module presc_split
  import fracn_seq_pkg::*;
#(
  parameter int N_W  = 10,
  parameter int SW_W = 3,
  parameter int MN_W = 8
) (
  input  logic [N_W-1:0]  n_i,
  input  presc_e          mode_i,
  output logic [SW_W-1:0] swallow_o,
  output logic [MN_W-1:0] main_o
);
  logic [SW_W-1:0] sw_arr [NUM_MODES];
  logic [MN_W-1:0] mn_arr [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    localparam int SH = P_LOG2_BASE + g;
    assign sw_arr[g] = SW_W'(n_i[SH-1:0]);
    assign mn_arr[g] = MN_W'(n_i >> SH);
  end

  assign swallow_o = sw_arr[mode_i];
  assign main_o    = mn_arr[mode_i];
endmodule

// File: rtl/fracn_ratio_seq.sv
module fracn_ratio_seq
  import fracn_seq_pkg::*;
#(
  parameter int INT_W     = 9,
  parameter int FRAC_W    = 12,
  parameter int DLY_W     = 12,
  parameter int N_MIN_LO  = 31,
  parameter int N_MIN_HI  = 91
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fb_tick,
  input  logic                chan_load,
  input  logic                cnt_hold,
  input  logic [INT_W-1:0]    int_val,
  input  logic [FRAC_W-1:0]   frac_val,
  input  logic [FRAC_W-1:0]   mod_val,
  input  logic                presc_sel,
  input  logic [DLY_W-1:0]    resync_dly,
  output logic [INT_W:0]      n_out,
  output logic [P_LOG2_BASE:0] swallow_out,
  output logic [INT_W-2:0]    main_out
  ,
  output logic                range_err
);
  localparam int N_W  = INT_W + 1;
  localparam int SW_W = P_LOG2_BASE + 1;
  localparam int MN_W = N_W - P_LOG2_BASE;

  presc_e          mode;
  logic            tick_go, acc_step, carry, busy;
  logic [N_W-1:0]  n_next, n_min;
  logic [SW_W-1:0] sw_next;
  logic [MN_W-1:0] mn_next;

  assign mode     = presc_e'(presc_sel);
  assign tick_go  = fb_tick && !cnt_hold && !chan_load;
  assign acc_step = tick_go && !busy;
  assign n_next   = {1'b0, int_val} + N_W'(acc_step && carry);
  assign n_min    = (mode == PS_8_9) ? N_W'(N_MIN_HI) : N_W'(N_MIN_LO);

  frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .hold    (cnt_hold),
    .clear   (chan_load),
    .step    (acc_step),
    .frac_i  (frac_val),
    .mod_i   (mod_val),
    .carry_o (carry)
  );

  resync_timer #(.DLY_W(DLY_W)) u_resync (
    .clk    (clk),
    .rst    (rst),
    .hold   (cnt_hold),
    .load   (chan_load),
    .tick   (tick_go),
    .dly_i  (resync_dly),
    .busy_o (busy)
  );

  presc_split #(.N_W(N_W), .SW_W(SW_W), .MN_W(MN_W)) u_split (
    .n_i       (n_next),
    .mode_i    (mode),
    .swallow_o (sw_next),
    .main_o    (mn_next)
  );

  always_ff @(posedge clk) begin
    if (rst || cnt_hold) begin
      n_out       <= '0;
      swallow_out <= '0;
      main_out    <= '0;
      range_err   <= 1'b0;
    end else if (tick_go) begin
      n_out       <= n_next;
      swallow_out <= sw_next;
      main_out    <= mn_next;
      range_err   <= (n_next < n_min);
    end
  end

  // R2
  n_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_go |=> ((n_out == {1'b0, $past(int_val)}) || (n_out == {1'b0, $past(int_val)} + 1'b1)));

  // R8
  resync_int_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_go && busy) |=> (n_out == {1'b0, $past(int_val)}));

  // R5 R6
  split_sum_chk: assert property (@(posedge clk) disable iff (rst)
    tick_go |=> (((N_W'(main_out) << (P_LOG2_BASE + int'($past(presc_sel)))) + N_W'(swallow_out)) == n_out));

  // R7
  range_flag_chk: assert property (@(posedge clk) disable iff (rst)
    tick_go |=> (range_err == (n_out < ($past(presc_sel) ? N_W'(N_MIN_HI) : N_W'(N_MIN_LO)))));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_hold |=> ((n_out == '0) && !range_err && (main_out == '0) && (swallow_out == '0)));

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_go && !cnt_hold) |=> ($stable(n_out) && $stable(range_err) && $stable(main_out) && $stable(swallow_out)));
endmodule

// File: tb/fracn_ratio_seq_tb_top.sv
module fracn_ratio_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst, fb_tick, chan_load, cnt_hold, presc_sel;
  logic [8:0]  int_val;
  logic [11:0] frac_val, mod_val, resync_dly;
  logic [9:0]  n_out;
  logic [2:0]  swallow_out;
  logic [7:0]  main_out;
  logic        range_err;

  int vec_cnt = 0;
  int err_cnt = 0;
  int m_acc   = 0;
  int m_wait  = 0;

  always #2 clk = ~clk;

  fracn_ratio_seq dut_i (
    .clk(clk), .rst(rst), .fb_tick(fb_tick), .chan_load(chan_load),
    .cnt_hold(cnt_hold), .int_val(int_val), .frac_val(frac_val),
    .mod_val(mod_val), .presc_sel(presc_sel), .resync_dly(resync_dly),
    .n_out(n_out), .swallow_out(swallow_out), .main_out(main_out),
    .range_err(range_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // golden model of one accepted tick, derived from R2, R4, R8, R9
  task automatic model_step(output int n);
    int fe, s;
    if (m_wait > 0) begin
      m_wait--;
      n = int'(int_val);
    end else if (mod_val == 0) begin
      n = int'(int_val);
    end else begin
      fe = (frac_val > mod_val) ? int'(mod_val) : int'(frac_val);
      s  = m_acc + fe;
      if (s >= int'(mod_val)) begin
        m_acc = s - int'(mod_val);
        n     = int'(int_val) + 1;
      end else begin
        m_acc = s;
        n     = int'(int_val);
      end
    end
  endtask

  task automatic do_tick(input string req, output int n_got);
    int ne, p;
    model_step(ne);
    @(negedge clk) fb_tick = 1'b1;
    @(negedge clk) fb_tick = 1'b0;
    p = presc_sel ? 8 : 4;
    n_got = int'(n_out);
    chk(int'(n_out) == ne, req, int'(n_out), ne);
    chk(int'(swallow_out) == ne % p, presc_sel ? "R6 swallow" : "R5 swallow", int'(swallow_out), ne % p);
    chk(int'(main_out) == ne / p, presc_sel ? "R6 main" : "R5 main", int'(main_out), ne / p);
    chk(int'(range_err) == int'(ne < (presc_sel ? 91 : 31)), "R7 flag", int'(range_err),
        int'(ne < (presc_sel ? 91 : 31)));
  endtask

  task automatic set_chan(input int i, input int f, input int m, input bit p, input int d);
    int prev;
    @(negedge clk);
    prev       = int'(n_out);
    int_val    = 9'(i);
    frac_val   = 12'(f);
    mod_val    = 12'(m);
    presc_sel  = p;
    resync_dly = 12'(d);
    chan_load  = 1'b1;
    fb_tick    = 1'b1;
    @(negedge clk);
    chan_load = 1'b0;
    fb_tick   = 1'b0;
    chk(int'(n_out) == prev, "R8 load tick ignored", int'(n_out), prev);
    m_acc  = 0;
    m_wait = d;
  endtask

  task automatic t_reset();
    rst = 1'b1; fb_tick = 1'b0; chan_load = 1'b0; cnt_hold = 1'b0;
    int_val = 9'd100; frac_val = '0; mod_val = 12'd1; presc_sel = 1'b0; resync_dly = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(n_out == 0, "R1 n_out", int'(n_out), 0);
    chk(swallow_out == 0 && main_out == 0, "R1 split", int'(main_out), 0);
    chk(range_err == 1'b0, "R1 flag", int'(range_err), 0);
  endtask

  task automatic t_integer();
    int n;
    set_chan(200, 0, 100, 1'b1, 0);
    repeat (3) do_tick("R2 integer", n);
  endtask

  task automatic t_frac_avg();
    int n, hi, tot;
    hi = 0; tot = 0;
    set_chan(100, 3, 7, 1'b1, 0);
    for (int k = 0; k < 7; k++) begin
      do_tick("R2 frac step", n);
      if (n == 101) hi++;
      tot += n;
    end
    chk(hi == 3, "R3 carry count", hi, 3);
    chk(tot == 703, "R3 ratio sum", tot, 703);
  endtask

  task automatic t_clamp();
    int n;
    set_chan(50, 9, 5, 1'b0, 0);
    for (int k = 0; k < 3; k++) begin
      do_tick("R4 frac over mod", n);
      chk(n == 51, "R4 clamp", n, 51);
    end
    set_chan(50, 5, 0, 1'b0, 0);
    for (int k = 0; k < 3; k++) begin
      do_tick("R4 mod zero", n);
      chk(n == 50, "R4 mod zero", n, 50);
    end
  endtask

  task automatic t_split();
    int n;
    set_chan(123, 1, 2, 1'b0, 0);
    repeat (4) do_tick("R5 split 4/5", n);
    set_chan(333, 0, 1, 1'b1, 0);
    repeat (2) do_tick("R6 split 8/9", n);
    set_chan(511, 1, 1, 1'b1, 0);
    do_tick("R6 top ratio", n);
    chk(n == 512, "R6 max N", n, 512);
  endtask

  task automatic t_range();
    int n;
    set_chan(30, 0, 10, 1'b0, 0); do_tick("R7 below 31", n);
    set_chan(31, 0, 10, 1'b0, 0); do_tick("R7 at 31", n);
    set_chan(30, 1, 1, 1'b0, 0);  do_tick("R7 carry to 31", n);
    set_chan(90, 0, 10, 1'b1, 0); do_tick("R7 below 91", n);
    set_chan(91, 0, 10, 1'b1, 0); do_tick("R7 at 91", n);
  endtask

  task automatic t_resync();
    int n;
    set_chan(60, 1, 2, 1'b0, 3);
    for (int k = 0; k < 3; k++) begin
      do_tick("R8 delay tick", n);
      chk(n == 60, "R8 delay INT", n, 60);
    end
    do_tick("R9 restart", n);
    chk(n == 60, "R9 first acc tick", n, 60);
    do_tick("R9 restart", n);
    chk(n == 61, "R9 second acc tick", n, 61);
  endtask

  task automatic t_hold();
    int n;
    set_chan(70, 1, 2, 1'b0, 0);
    do_tick("R2 pre-hold", n);
    @(negedge clk);
    cnt_hold = 1'b1; fb_tick = 1'b1; chan_load = 1'b1; resync_dly = 12'd5;
    repeat (3) @(negedge clk);
    chk(n_out == 0, "R10 n held", int'(n_out), 0);
    chk(main_out == 0 && swallow_out == 0, "R10 split held", int'(main_out), 0);
    cnt_hold = 1'b0; fb_tick = 1'b0; chan_load = 1'b0;
    m_acc = 0; m_wait = 0;
    do_tick("R10 acc cleared", n);
    chk(n == 70, "R10 after hold", n, 70);
  endtask

  task automatic t_idle();
    int prev;
    @(negedge clk);
    prev = int'(n_out);
    int_val = 9'd7; presc_sel = 1'b1;
    repeat (5) @(negedge clk);
    chk(int'(n_out) == prev, "R11 idle hold", int'(n_out), prev);
  endtask

  initial begin
    #(4 * 200000);
    err_cnt++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    t_reset();
    t_integer();
    t_frac_avg();
    t_clamp();
    t_split();
    t_range();
    t_resync();
    t_hold();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule